// File: doc/BRIEF.md
# Trap and Interrupt Entry Unit

This block holds the control state that a small processor touches when it enters an exception. It keeps a 32-bit status word, a backup copy and a debug copy of that word, a backup PC and a debug PC, and a working stack pointer with two banked stack pointers behind it. It is written once per clock edge, by one of these sources: an ordinary trap, a debug trap, an instruction-address breakpoint, the maskable external interrupt line, or a plain software write of the status word.

Two of these sources transfer control. A breakpoint sends the PC to 0xFFFFF128 and an interrupt sends it to 0xFFFFF138. The transfer shows as a one-cycle redirect pulse that carries the vector. Ordinary and debug traps only reshape the status word, and their vectors are chosen elsewhere in the pipeline. An interrupt that arrives while interrupts are masked is held in a single pending slot. Any edge that changes the stack-mode bit exchanges the working stack pointer with the other bank.

Top module: `trap_entry_unit`

## Requirements
- R1: During reset and after it is released, every register output reads zero. This covers the bank select, the pending flag and the redirect pulse.
- R2: Status bits are numbered from the MSB, so bit position k is bit 31-k of the word. The default positions are SM=0, EA=2, DB=3, DS=4 and IE=5. When no trap or interrupt is taken, a status write loads the written word.
- R3: An ordinary trap copies the status word into the backup status register and keeps only DB and SM.
- R4: A debug trap copies the status word into the debug status register. The status word then reads DS alone.
- R5: A breakpoint has these effects: the debug PC takes the next PC, the debug status takes the old status with EA set, the status keeps SM and gains DS, and the redirect vector is 0xFFFFF128.
- R6: A breakpoint fires only when an instruction retires, its address equals the breakpoint address, and DB is set. Any other case changes nothing.
- R7: An interrupt taken with IE set has these effects: the backup status and backup PC take the old status and the next PC, the status word clears, and the redirect vector is 0xFFFFF138.
- R8: An interrupt seen with IE clear sets the pending flag. Requests that arrive while the flag is set are dropped. The pending request is delivered on the first edge at which IE reads set, and delivery clears the flag.
- R9: The bank select always equals SM. When SM changes, the working SP (or the SP being written that cycle) is stored in the old bank, and the working SP is loaded from the new bank.
- R10: Priority from high to low is breakpoint, debug trap, ordinary trap, interrupt, status write. An interrupt that loses to a trap becomes pending, and a status write in a cycle that takes a trap or an interrupt is ignored.
- R11: The redirect output pulses for exactly one cycle after each breakpoint or interrupt. At all other times it reads zero, with a zero vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | An instruction retires this cycle |
| cur_pc_i | input | 32 | Address of the retiring instruction |
| nxt_pc_i | input | 32 | PC after jump and loop decisions |
| brk_addr_i | input | 32 | Breakpoint address |
| trap_i | input | 1 | Ordinary trap request |
| dbg_trap_i | input | 1 | Debug trap request |
| irq_i | input | 1 | External interrupt request |
| sts_we_i | input | 1 | Status write enable |
| sts_wdata_i | input | 32 | Status write data |
| sp_we_i | input | 1 | Working SP write enable |
| sp_wdata_i | input | 32 | Working SP write data |
| status_o | output | 32 | Status word |
| bak_status_o | output | 32 | Backup status |
| dbg_status_o | output | 32 | Debug status |
| bak_pc_o | output | 32 | Backup PC |
| dbg_pc_o | output | 32 | Debug PC |
| sp_o | output | 32 | Working stack pointer |
| sp_bank0_o | output | 32 | Stored bank 0 stack pointer |
| sp_bank1_o | output | 32 | Stored bank 1 stack pointer |
| sp_sel_o | output | 1 | Active bank |
| irq_pending_o | output | 1 | Masked interrupt waiting |
| redirect_o | output | 1 | PC redirect pulse |
| redirect_pc_o | output | 32 | Redirect vector |

## Verification
A wrong status mask shows at status_o on the edge right after the trap. A wrong bank select shows as an SP value from the wrong bank on the same edge. A pending flag that is set or cleared wrongly is harder to see: it shows only as an interrupt vector that appears, or fails to appear, on the first edge after software raises IE, which can be many cycles later. For this reason the bench compares every register output after every cycle against a model, so a corrupted copy register is caught where it first diverges, not only when it is read.

// File: rtl/trap_entry_unit.sv
module trap_entry_unit #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int SM_POS = 0,
  parameter int EA_POS = 2,
  parameter int DB_POS = 3,
  parameter int DS_POS = 4,
  parameter int IE_POS = 5,
  parameter logic [AW-1:0] BRK_VEC = 32'hFFFF_F128,
  parameter logic [AW-1:0] IRQ_VEC = 32'hFFFF_F138
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic [AW-1:0] cur_pc_i,
  input  logic [AW-1:0] nxt_pc_i,
  input  logic [AW-1:0] brk_addr_i,
  input  logic          trap_i,
  input  logic          dbg_trap_i,
  input  logic          irq_i,
  input  logic          sts_we_i,
  input  logic [DW-1:0] sts_wdata_i,
  input  logic          sp_we_i,
  input  logic [AW-1:0] sp_wdata_i,
  output logic [DW-1:0] status_o,
  output logic [DW-1:0] bak_status_o,
  output logic [DW-1:0] dbg_status_o,
  output logic [AW-1:0] bak_pc_o,
  output logic [AW-1:0] dbg_pc_o,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] sp_bank0_o,
  output logic [AW-1:0] sp_bank1_o,
  output logic          sp_sel_o,
  output logic          irq_pending_o,
  output logic          redirect_o,
  output logic [AW-1:0] redirect_pc_o
);
  localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] M_SM = ONE << (DW-1-SM_POS);
  localparam logic [DW-1:0] M_EA = ONE << (DW-1-EA_POS);
  localparam logic [DW-1:0] M_DB = ONE << (DW-1-DB_POS);
  localparam logic [DW-1:0] M_DS = ONE << (DW-1-DS_POS);
  localparam logic [DW-1:0] M_IE = ONE << (DW-1-IE_POS);

  logic [DW-1:0] sts_q, bks_q, dbs_q, sts_d;
  logic [AW-1:0] bkpc_q, dbpc_q, sp_q, bank0_q, bank1_q, rpc_q, sp_eff, bank_new;
  logic          sel_q, pend_q, redir_q, sel_d;

  wire ie_on    = |(sts_q & M_IE);
  wire db_on    = |(sts_q & M_DB);
  wire brk_hit  = step_i && (cur_pc_i == brk_addr_i) && db_on;
  wire dbg_hit  = !brk_hit && dbg_trap_i;
  wire ord_hit  = !brk_hit && !dbg_trap_i && trap_i;
  wire sync_hit = brk_hit || dbg_trap_i || trap_i;
  wire irq_hit  = (irq_i || pend_q) && ie_on && !sync_hit;
  wire sw_hit   = sts_we_i && !sync_hit && !irq_hit;

  always_comb begin
    sts_d = sts_q;
    if (brk_hit)      sts_d = (sts_q & M_SM) | M_DS;
    else if (dbg_hit) sts_d = M_DS;
    else if (ord_hit) sts_d = sts_q & (M_DB | M_SM);
    else if (irq_hit) sts_d = '0;
    else if (sw_hit)  sts_d = sts_wdata_i;
  end

  assign sel_d    = |(sts_d & M_SM);
  assign sp_eff   = sp_we_i ? sp_wdata_i : sp_q;
  assign bank_new = sel_d ? bank1_q : bank0_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q   <= '0;
      bks_q   <= '0;
      dbs_q   <= '0;
      bkpc_q  <= '0;
      dbpc_q  <= '0;
      sp_q    <= '0;
      bank0_q <= '0;
      bank1_q <= '0;
      sel_q   <= 1'b0;
      pend_q  <= 1'b0;
      redir_q <= 1'b0;
      rpc_q   <= '0;
    end else begin
      sts_q <= sts_d;
      if (brk_hit) begin
        dbpc_q <= nxt_pc_i;
        dbs_q  <= sts_q | M_EA;
      end
      if (dbg_hit) dbs_q <= sts_q;
      if (ord_hit) bks_q <= sts_q;
      if (irq_hit) begin
        bks_q  <= sts_q;
        bkpc_q <= nxt_pc_i;
      end
      redir_q <= brk_hit || irq_hit;
      rpc_q   <= brk_hit ? BRK_VEC : (irq_hit ? IRQ_VEC : '0);
      pend_q  <= irq_hit ? 1'b0 : (pend_q || irq_i);
      if (sel_d != sel_q) begin
        if (sel_q) bank1_q <= sp_eff;
        else       bank0_q <= sp_eff;
        sp_q  <= bank_new;
        sel_q <= sel_d;
      end else begin
        sp_q <= sp_eff;
      end
    end
  end

  assign status_o      = sts_q;
  assign bak_status_o  = bks_q;
  assign dbg_status_o  = dbs_q;
  assign bak_pc_o      = bkpc_q;
  assign dbg_pc_o      = dbpc_q;
  assign sp_o          = sp_q;
  assign sp_bank0_o    = bank0_q;
  assign sp_bank1_o    = bank1_q;
  assign sp_sel_o      = sel_q;
  assign irq_pending_o = pend_q;
  assign redirect_o    = redir_q;
  assign redirect_pc_o = rpc_q;
endmodule

// File: rtl/trap_entry_unit_chk.sv
module trap_entry_unit_chk #(
  parameter int DW = 32,
  parameter int AW = 32,
  parameter int SM_POS = 0,
  parameter int DS_POS = 4,
  parameter int IE_POS = 5,
  parameter logic [AW-1:0] BRK_VEC = 32'hFFFF_F128,
  parameter logic [AW-1:0] IRQ_VEC = 32'hFFFF_F138
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] status_o,
  input logic          sp_sel_o,
  input logic          irq_pending_o,
  input logic          redirect_o,
  input logic [AW-1:0] redirect_pc_o
);
  localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] M_SM = ONE << (DW-1-SM_POS);
  localparam logic [DW-1:0] M_DS = ONE << (DW-1-DS_POS);
  localparam logic [DW-1:0] M_IE = ONE << (DW-1-IE_POS);

  a_r11_known_vector: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_o |-> (redirect_pc_o == BRK_VEC || redirect_pc_o == IRQ_VEC));

  a_r9_bank_tracks_sm: assert property (@(posedge clk) disable iff (!rst_n)
    sp_sel_o == |(status_o & M_SM));

  a_r7_irq_clears_status: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && redirect_pc_o == IRQ_VEC) |-> status_o == '0);

  a_r5_brk_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (redirect_o && redirect_pc_o == BRK_VEC) |-> ((status_o & ~(M_SM | M_DS)) == '0 && (status_o & M_DS) != '0));

  a_r8_pending_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pending_o && (status_o & M_IE) == '0) |=> irq_pending_o);
endmodule

bind trap_entry_unit trap_entry_unit_chk #(
  .DW(DW), .AW(AW), .SM_POS(SM_POS), .DS_POS(DS_POS), .IE_POS(IE_POS),
  .BRK_VEC(BRK_VEC), .IRQ_VEC(IRQ_VEC)
) u_chk (.*);

// File: tb/test_trap_entry_unit.sv
`timescale 1ns/1ps
module test_trap_entry_unit;
  localparam logic [31:0] SM = 32'h8000_0000, EA = 32'h2000_0000, DB = 32'h1000_0000;
  localparam logic [31:0] DS = 32'h0800_0000, IE = 32'h0400_0000;
  localparam logic [31:0] VBRK = 32'hFFFF_F128, VIRQ = 32'hFFFF_F138;

  logic clk = 0, rst_n = 0;
  logic step_i = 0, trap_i = 0, dbg_trap_i = 0, irq_i = 0, sts_we_i = 0, sp_we_i = 0;
  logic [31:0] cur_pc_i = 0, nxt_pc_i = 0, brk_addr_i = 0, sts_wdata_i = 0, sp_wdata_i = 0;
  logic [31:0] status_o, bak_status_o, dbg_status_o, bak_pc_o, dbg_pc_o, sp_o, sp_bank0_o, sp_bank1_o, redirect_pc_o;
  logic sp_sel_o, irq_pending_o, redirect_o;

  always #2.5 clk = ~clk;

  trap_entry_unit i_trap_entry_unit (.*);

  typedef struct {
    logic [31:0] sts, bks, dbs, bkpc, dbpc, sp, b0, b1, rpc;
    logic sel, pend, redir;
    string tag;
  } exp_t;
  exp_t q[$];
  exp_t m;
  int vecs = 0, errs = 0;

  task automatic cmp(string tag, string name, logic [31:0] act, logic [31:0] exp);
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, name, act, exp);
    end
  endtask

  task automatic check_all(exp_t e);
    vecs++;
    cmp(e.tag, "status", status_o, e.sts);
    cmp(e.tag, "bak_status", bak_status_o, e.bks);
    cmp(e.tag, "dbg_status", dbg_status_o, e.dbs);
    cmp(e.tag, "bak_pc", bak_pc_o, e.bkpc);
    cmp(e.tag, "dbg_pc", dbg_pc_o, e.dbpc);
    cmp(e.tag, "sp", sp_o, e.sp);
    cmp(e.tag, "bank0", sp_bank0_o, e.b0);
    cmp(e.tag, "bank1", sp_bank1_o, e.b1);
    cmp(e.tag, "sel", {31'd0, sp_sel_o}, {31'd0, e.sel});
    cmp(e.tag, "pending", {31'd0, irq_pending_o}, {31'd0, e.pend});
    cmp(e.tag, "redirect", {31'd0, redirect_o}, {31'd0, e.redir});
    cmp(e.tag, "redirect_pc", redirect_pc_o, e.rpc);
  endtask

  // driver: applies one cycle of stimulus and pushes the model's expected state
  task automatic cyc(string tag, logic tr = 0, logic dt = 0, logic irq = 0, logic stp = 0,
                     logic [31:0] cpc = 0, logic [31:0] npc = 0, logic [31:0] brk = 0,
                     logic swe = 0, logic [31:0] swd = 0, logic spwe = 0, logic [31:0] spwd = 0);
    logic brk_t, irq_t, any_t, nsel;
    logic [31:0] old, spe;
    trap_i = tr; dbg_trap_i = dt; irq_i = irq; step_i = stp; cur_pc_i = cpc; nxt_pc_i = npc;
    brk_addr_i = brk; sts_we_i = swe; sts_wdata_i = swd; sp_we_i = spwe; sp_wdata_i = spwd;
    old = m.sts;
    brk_t = stp && cpc == brk && (old & DB) != 0;
    any_t = brk_t || dt || tr;
    irq_t = (irq || m.pend) && (old & IE) != 0 && !any_t;
    m.redir = brk_t || irq_t;
    m.rpc = brk_t ? VBRK : (irq_t ? VIRQ : 32'h0);
    if (brk_t) begin m.dbpc = npc; m.dbs = old | EA; m.sts = (old & SM) | DS; end
    else if (dt) begin m.dbs = old; m.sts = DS; end
    else if (tr) begin m.bks = old; m.sts = old & (DB | SM); end
    else if (irq_t) begin m.bks = old; m.bkpc = npc; m.sts = 0; end
    else if (swe) m.sts = swd;
    m.pend = irq_t ? 1'b0 : (m.pend || irq);
    spe = spwe ? spwd : m.sp;
    nsel = (m.sts & SM) != 0;
    if (nsel != m.sel) begin
      if (m.sel) m.b1 = spe; else m.b0 = spe;
      m.sp = nsel ? m.b1 : m.b0;
      m.sel = nsel;
    end else m.sp = spe;
    m.tag = tag;
    q.push_back(m);
    @(negedge clk);
  endtask

  // monitor: compares after each edge
  initial forever begin
    @(posedge clk); #1;
    if (q.size() > 0) check_all(q.pop_front());
  end

  initial begin
    #(200000 * 5);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    m = '{sts:0, bks:0, dbs:0, bkpc:0, dbpc:0, sp:0, b0:0, b1:0, rpc:0, sel:0, pend:0, redir:0, tag:"R1"};
    repeat (3) @(negedge clk);
    m.tag = "R1 reset";
    check_all(m);
    rst_n = 1;
    cyc("R1 idle after reset");
    // R2 and R9: status write, SP banking
    cyc("R9 sp write", .spwe(1), .spwd(32'h1000));
    cyc("R9 set SM swaps bank", .swe(1), .swd(SM));
    cyc("R9 sp write bank1", .spwe(1), .spwd(32'h2000));
    cyc("R9 clear SM with sp write", .swe(1), .swd(0), .spwe(1), .spwd(32'h2400));
    cyc("R2 status write", .swe(1), .swd(32'hFFFF_FFFF));
    // R3 ordinary trap
    cyc("R3 ordinary trap", .tr(1));
    // R4 debug trap (SM drops, bank swap)
    cyc("R4 debug trap", .dt(1));
    // R6 breakpoint not taken: DB clear, address mismatch, no step
    cyc("R6 DB clear", .stp(1), .cpc(32'h40), .npc(32'h48), .brk(32'h40));
    cyc("R2 set DB SM IE", .swe(1), .swd(DB | SM | IE | 32'h3));
    cyc("R6 address mismatch", .stp(1), .cpc(32'h44), .npc(32'h4C), .brk(32'h40));
    cyc("R6 no retire", .stp(0), .cpc(32'h40), .npc(32'h48), .brk(32'h40));
    // R5 and R10: breakpoint with interrupt in the same cycle, software write ignored
    cyc("R5 R10 breakpoint over irq", .irq(1), .stp(1), .cpc(32'h40), .npc(32'h48), .brk(32'h40),
        .swe(1), .swd(32'h5));
    cyc("R11 pulse ends");
    cyc("R8 enable delivers pending", .swe(1), .swd(IE | SM));
    cyc("R7 R8 pending delivered", .npc(32'h88));
    cyc("R11 idle");
    // R8 masked request then dropped extra
    cyc("R8 masked irq", .irq(1));
    cyc("R8 second irq dropped", .irq(1));
    cyc("R8 still waiting");
    cyc("R8 raise IE", .swe(1), .swd(IE));
    cyc("R8 delivery", .npc(32'h100));
    cyc("R8 nothing left");
    // R7 direct interrupt
    cyc("R2 set IE DB", .swe(1), .swd(IE | DB | 32'h10));
    cyc("R7 irq taken", .irq(1), .npc(32'h200));
    // R10 debug beats ordinary, ordinary beats irq
    cyc("R2 set flags", .swe(1), .swd(IE | DB | SM | 32'hF0));
    cyc("R10 debug over ordinary", .tr(1), .dt(1));
    cyc("R2 restore", .swe(1), .swd(IE | SM | 32'h1));
    cyc("R10 ordinary over irq", .tr(1), .irq(1), .npc(32'h300));
    cyc("R10 irq still pending");
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule